// File: doc/BRIEF.md
# Display panel power sequencer

This block controls the enable lines of an LCD bias supply and the two output-enable lines of a panel gate driver. It brings up three rails in a fixed order: the DC/DC converter, then the source-side regulator, then the gate-side regulator. Each step waits a programmable number of clock cycles. Once the rails are up, a display-on command raises the main output enable. A standby command brings the panel down again. The main output enable falls at once and the clamp enable falls at the next frame start. The block then waits one full frame so the panel can discharge, and lowers the rails in the reverse order.

Four commands drive it, each a single-cycle pulse: power-up, display-on, standby and reset. An active-low asynchronous reset puts every output in the safe state: all rails off, the main enable low and the clamp enable high. A reset command does the same, but it is accepted only once a guard interval has passed since the reset was released. All delay inputs are terminal counts in clock cycles. A count of N gives a gap of N+1 cycles between the two steps.

Top module: `panel_pwr_seq`

## Requirements
- R1: While `rst_n` is low, `conv_en`, `src_reg_en`, `gate_reg_en`, `oe_main` and `busy` are 0 and `oe_clamp` is 1. This holds even if `rst_n` falls in the middle of a sequence.
- R2: An accepted `cmd_reset` puts all outputs in the R1 safe state at the clock edge that samples it, from any state, aborting any sequence.
- R3: A `cmd_reset` sampled fewer than GUARD_CYCLES (default 5, which is 100 ns at 50 MHz) clock edges after `rst_n` rises is ignored.
- R4: A `cmd_pwr_up` sampled in an off state raises `conv_en` at that same edge. `src_reg_en` rises `tc_conv_to_src`+1 cycles later, and `gate_reg_en` rises `tc_src_to_gate`+1 cycles after that.
- R5: With all rails up and the gate delay expired, `cmd_display_on` raises `oe_main` at the edge that samples it.
- R6: A `cmd_display_on` received during power-up is held. `oe_main` then rises `tc_gate_to_oe`+1 cycles after `gate_reg_en` rises.
- R7: `cmd_display_on` has no effect while the rails are off.
- R8: A `cmd_standby` from the rails-up or display state drops `oe_main` at the edge that samples it. `oe_clamp` drops at the edge that samples the next `frame_start`.
- R9: After `oe_clamp` falls, the next `frame_start` lowers `gate_reg_en`. `src_reg_en` falls `tc_gate_off_to_src`+1 cycles after that, and `conv_en` falls `tc_src_off_to_conv`+1 cycles after `src_reg_en`.
- R10: A terminal count of 0 gives a one-cycle gap between steps, and the order of steps is kept.
- R11: `busy` is 1 in every power-up, standby-wait and power-down step. It is 0 in the safe, rails-up, display and powered-off states.
- R12: While `busy` is 1, `cmd_pwr_up`, `cmd_standby` and `cmd_display_on` are ignored. The one exception is the display-on hold of R6 during power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_pwr_up | input | 1 | Power-up command pulse |
| cmd_reset | input | 1 | Reset command pulse |
| cmd_display_on | input | 1 | Display-on command pulse |
| cmd_standby | input | 1 | Standby command pulse |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| tc_conv_to_src | input | TCW | Cycles from converter on to source regulator on, minus 1 |
| tc_src_to_gate | input | TCW | Cycles from source regulator on to gate regulator on, minus 1 |
| tc_gate_to_oe | input | TCW | Cycles from gate regulator on to the held display-on taking effect, minus 1 |
| tc_gate_off_to_src | input | TCW | Cycles from gate regulator off to source regulator off, minus 1 |
| tc_src_off_to_conv | input | TCW | Cycles from source regulator off to converter off, minus 1 |
| conv_en | output | 1 | DC/DC converter enable |
| src_reg_en | output | 1 | Source-side regulator enable |
| gate_reg_en | output | 1 | Gate-side regulator enable |
| oe_main | output | 1 | Main gate output enable; low in the safe state |
| oe_clamp | output | 1 | Clamp output enable; high in the safe state |
| busy | output | 1 | A sequence is in progress |

## Verification
Every output is decoded from a single state register. A wrong state therefore shows up at the ports in the same cycle, as an enable pattern that breaks the order, or as a `busy` level that does not match the enables. A timer that loads or compares wrongly does not break the order. It shows only as a gap that is off by some cycles, so the bench measures every gap in cycles against the terminal counts. A lost or wrong display-on hold can only be seen tc_gate_to_oe+1 cycles after the gate regulator rises, so the bench watches that window.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [3:0] {
    ST_SAFE,
    ST_PU_CONV,
    ST_PU_SRC,
    ST_PU_GATE,
    ST_RAILS,
    ST_DISP,
    ST_SB_WAIT,
    ST_SB_DISCH,
    ST_PD_SRC,
    ST_PD_CONV,
    ST_OFF
  } seq_state_e;

  typedef struct packed {
    logic conv;
    logic src;
    logic gate;
    logic oe_main;
    logic oe_clamp;
    logic busy;
  } rail_ctl_t;
endpackage

// File: rtl/pps_guard.sv
module pps_guard #(
  parameter int GUARD_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic guard_ok
);
  localparam int GW = $clog2(GUARD_CYCLES + 2);
  localparam logic [GW-1:0] GLIM = GW'(GUARD_CYCLES);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt != GLIM) cnt <= cnt + 1'b1;
  end

  assign guard_ok = (cnt == GLIM);

  // R3: once the guard opens it stays open until the next reset
  a_r3_guard_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    guard_ok |=> guard_ok);
endmodule

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int TCW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic [TCW-1:0] tc,
  output logic           done
);
  logic [TCW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (restart) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == tc);
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_pwr_up,
  input  logic       cmd_reset,
  input  logic       cmd_display_on,
  input  logic       cmd_standby,
  input  logic       frame_start,
  input  logic       guard_ok,
  input  logic       t_done,
  output seq_state_e state,
  output logic       restart
);
  seq_state_e state_nx;
  logic       pend;
  logic       cur_pu, nx_pu;

  assign cur_pu = (state == ST_PU_CONV) || (state == ST_PU_SRC) || (state == ST_PU_GATE);
  assign nx_pu  = (state_nx == ST_PU_CONV) || (state_nx == ST_PU_SRC) || (state_nx == ST_PU_GATE);

  always_comb begin
    state_nx = state;
    case (state)
      ST_SAFE, ST_OFF: if (cmd_pwr_up) state_nx = ST_PU_CONV;
      ST_PU_CONV:      if (t_done) state_nx = ST_PU_SRC;
      ST_PU_SRC:       if (t_done) state_nx = ST_PU_GATE;
      ST_PU_GATE:      if (t_done) state_nx = (pend || cmd_display_on) ? ST_DISP : ST_RAILS;
      ST_RAILS: begin
        if (cmd_standby) state_nx = ST_SB_WAIT;
        else if (cmd_display_on) state_nx = ST_DISP;
      end
      ST_DISP:         if (cmd_standby) state_nx = ST_SB_WAIT;
      ST_SB_WAIT:      if (frame_start) state_nx = ST_SB_DISCH;
      ST_SB_DISCH:     if (frame_start) state_nx = ST_PD_SRC;
      ST_PD_SRC:       if (t_done) state_nx = ST_PD_CONV;
      ST_PD_CONV:      if (t_done) state_nx = ST_OFF;
      default:         state_nx = ST_SAFE;
    endcase
    if (cmd_reset && guard_ok) state_nx = ST_SAFE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_SAFE;
      pend  <= 1'b0;
    end else begin
      state <= state_nx;
      pend  <= nx_pu && (pend || (cur_pu && cmd_display_on));
    end
  end

  assign restart = (state_nx != state);

  // R6: a held display-on never survives outside the power-up steps
  a_r6_hold_only_in_rampup: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> cur_pu);
endmodule

// File: rtl/pps_outdec.sv
module pps_outdec
  import pps_pkg::*;
(
  input  seq_state_e state,
  output rail_ctl_t  ctl
);
  always_comb begin
    ctl = '{conv: 1'b0, src: 1'b0, gate: 1'b0, oe_main: 1'b0, oe_clamp: 1'b1, busy: 1'b0};
    case (state)
      ST_SAFE:     ctl = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      ST_PU_CONV:  ctl = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
      ST_PU_SRC:   ctl = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
      ST_PU_GATE:  ctl = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
      ST_RAILS:    ctl = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
      ST_DISP:     ctl = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
      ST_SB_WAIT:  ctl = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
      ST_SB_DISCH: ctl = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
      ST_PD_SRC:   ctl = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
      ST_PD_CONV:  ctl = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      ST_OFF:      ctl = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      default:     ctl = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    endcase
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int TCW          = 24,
  parameter int GUARD_CYCLES = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_pwr_up,
  input  logic           cmd_reset,
  input  logic           cmd_display_on,
  input  logic           cmd_standby,
  input  logic           frame_start,
  input  logic [TCW-1:0] tc_conv_to_src,
  input  logic [TCW-1:0] tc_src_to_gate,
  input  logic [TCW-1:0] tc_gate_to_oe,
  input  logic [TCW-1:0] tc_gate_off_to_src,
  input  logic [TCW-1:0] tc_src_off_to_conv,
  output logic           conv_en,
  output logic           src_reg_en,
  output logic           gate_reg_en,
  output logic           oe_main,
  output logic           oe_clamp,
  output logic           busy
);
  seq_state_e     state;
  logic           restart, t_done, guard_ok;
  logic [TCW-1:0] tc_sel;
  rail_ctl_t      ctl;

  pps_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
    .clk(clk), .rst_n(rst_n), .guard_ok(guard_ok)
  );

  always_comb begin
    case (state)
      ST_PU_CONV: tc_sel = tc_conv_to_src;
      ST_PU_SRC:  tc_sel = tc_src_to_gate;
      ST_PU_GATE: tc_sel = tc_gate_to_oe;
      ST_PD_SRC:  tc_sel = tc_gate_off_to_src;
      ST_PD_CONV: tc_sel = tc_src_off_to_conv;
      default:    tc_sel = '0;
    endcase
  end

  pps_timer #(.TCW(TCW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tc(tc_sel), .done(t_done)
  );

  pps_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_pwr_up(cmd_pwr_up), .cmd_reset(cmd_reset),
    .cmd_display_on(cmd_display_on), .cmd_standby(cmd_standby),
    .frame_start(frame_start), .guard_ok(guard_ok), .t_done(t_done),
    .state(state), .restart(restart)
  );

  pps_outdec u_dec (.state(state), .ctl(ctl));

  assign conv_en     = ctl.conv;
  assign src_reg_en  = ctl.src;
  assign gate_reg_en = ctl.gate;
  assign oe_main     = ctl.oe_main;
  assign oe_clamp    = ctl.oe_clamp;
  assign busy        = ctl.busy;

  // R4: the source regulator only rises while the converter was already on
  a_r4_src_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_reg_en) |-> $past(conv_en));
  // R4: the gate regulator only rises after the source regulator
  a_r4_gate_after_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_reg_en) |-> $past(src_reg_en));
  // R9: on an orderly power-down the source regulator falls after the gate regulator
  a_r9_src_off_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(src_reg_en) && !oe_clamp) |-> $past(!gate_reg_en));
  // R9: on an orderly power-down the converter is the last to fall
  a_r9_conv_off_last: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_en) && !oe_clamp) |-> $past(!src_reg_en));
  // R5: the main enable only rises on a fully powered panel
  a_r5_oe_needs_rails: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_main) |-> ($past(gate_reg_en) && src_reg_en && conv_en));
  // R11: starting a ramp always raises busy
  a_r11_busy_on_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_en) |-> busy);
endmodule

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb;
  localparam int TCW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_pwr_up = 1'b0, cmd_reset = 1'b0, cmd_display_on = 1'b0, cmd_standby = 1'b0;
  logic frame_start = 1'b0;
  logic [TCW-1:0] tc_cs = 6, tc_sg = 3, tc_go = 4, tc_gs = 2, tc_sc = 5;
  logic conv_en, src_reg_en, gate_reg_en, oe_main, oe_clamp, busy;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  panel_pwr_seq #(.TCW(TCW), .GUARD_CYCLES(5)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_pwr_up(cmd_pwr_up), .cmd_reset(cmd_reset),
    .cmd_display_on(cmd_display_on), .cmd_standby(cmd_standby),
    .frame_start(frame_start),
    .tc_conv_to_src(tc_cs), .tc_src_to_gate(tc_sg), .tc_gate_to_oe(tc_go),
    .tc_gate_off_to_src(tc_gs), .tc_src_off_to_conv(tc_sc),
    .conv_en(conv_en), .src_reg_en(src_reg_en), .gate_reg_en(gate_reg_en),
    .oe_main(oe_main), .oe_clamp(oe_clamp), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return conv_en;
      1: return src_reg_en;
      2: return gate_reg_en;
      3: return oe_main;
      default: return oe_clamp;
    endcase
  endfunction

  // sel: 0 power-up, 1 reset, 2 display-on, 3 standby, 4 frame start
  task automatic pulse(input int sel);
    @(negedge clk);
    case (sel)
      0: cmd_pwr_up = 1'b1;
      1: cmd_reset = 1'b1;
      2: cmd_display_on = 1'b1;
      3: cmd_standby = 1'b1;
      default: frame_start = 1'b1;
    endcase
    @(negedge clk);
    cmd_pwr_up = 1'b0; cmd_reset = 1'b0; cmd_display_on = 1'b0;
    cmd_standby = 1'b0; frame_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gap(input int sel, input logic val, output int n);
    n = 0;
    while (sig(sel) != val && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_safe(input string req);
    check({req, " conv"}, conv_en, 0);
    check({req, " src"}, src_reg_en, 0);
    check({req, " gate"}, gate_reg_en, 0);
    check({req, " oe_main"}, oe_main, 0);
    check({req, " oe_clamp"}, oe_clamp, 1);
    check({req, " busy"}, busy, 0);
  endtask

  task automatic t_reset_and_guard;
    idle(3);
    check_safe("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    tc_cs = 50;
    pulse(0);
    check("R4 conv on", conv_en, 1);
    pulse(1);
    check("R3 early reset ignored", conv_en, 1);
    idle(10);
    pulse(1);
    check_safe("R2 reset cmd aborts");
    pulse(2);
    idle(3);
    check("R7 display-on while off oe_main", oe_main, 0);
    check("R7 display-on while off conv", conv_en, 0);
  endtask

  task automatic t_powerup;
    int n;
    tc_cs = 6; tc_sg = 3; tc_go = 4;
    pulse(0);
    check("R11 busy in ramp", busy, 1);
    gap(1, 1'b1, n);
    check("R4 src gap", n, 7);
    gap(2, 1'b1, n);
    check("R4 gate gap", n, 4);
    idle(4);
    check("R11 busy before gate delay ends", busy, 1);
    idle(1);
    check("R11 busy low when rails up", busy, 0);
    check("R5 oe_main still low", oe_main, 0);
    pulse(2);
    check("R5 display-on raises oe_main", oe_main, 1);
  endtask

  task automatic t_standby;
    int n;
    tc_gs = 2; tc_sc = 5;
    pulse(3);
    check("R8 oe_main falls on standby", oe_main, 0);
    check("R8 oe_clamp held", oe_clamp, 1);
    pulse(0);
    check("R12 power-up ignored when busy", busy, 1);
    idle(3);
    pulse(4);
    check("R8 oe_clamp falls on frame", oe_clamp, 0);
    check("R9 gate held during discharge", gate_reg_en, 1);
    idle(2);
    pulse(2);
    check("R12 display-on ignored when busy", oe_main, 0);
    pulse(4);
    check("R9 gate off after frame", gate_reg_en, 0);
    check("R9 src still on", src_reg_en, 1);
    gap(1, 1'b0, n);
    check("R9 src off gap", n, 3);
    gap(0, 1'b0, n);
    check("R9 conv off gap", n, 6);
    check("R11 busy low when off", busy, 0);
    check("R9 oe_clamp low when off", oe_clamp, 0);
  endtask

  task automatic t_latched;
    int n;
    tc_cs = 6; tc_sg = 3; tc_go = 4;
    pulse(0);
    idle(1);
    pulse(2);
    pulse(3);
    gap(2, 1'b1, n);
    check("R12 standby in ramp ignored", oe_clamp, 1);
    gap(3, 1'b1, n);
    check("R6 held display-on gap", n, 5);
  endtask

  task automatic t_zero;
    int n;
    pulse(1);
    check_safe("R2 reset from display");
    tc_cs = 0; tc_sg = 0; tc_go = 0; tc_gs = 0; tc_sc = 0;
    pulse(0);
    gap(1, 1'b1, n);
    check("R10 src gap zero", n, 1);
    gap(2, 1'b1, n);
    check("R10 gate gap zero", n, 1);
    idle(1);
    pulse(3);
    pulse(4);
    pulse(4);
    check("R10 gate off", gate_reg_en, 0);
    gap(1, 1'b0, n);
    check("R10 src off gap zero", n, 1);
    gap(0, 1'b0, n);
    check("R10 conv off gap zero", n, 1);
  endtask

  task automatic t_async_mid;
    tc_cs = 6; tc_sg = 20;
    pulse(0);
    idle(9);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check_safe("R1 async reset mid ramp");
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_and_guard();
    t_powerup();
    t_standby();
    t_latched();
    t_zero();
    t_async_mid();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule